// File: doc/BRIEF.md
# Privilege Mode and Trap Controller

This block runs beside a simple in-order CPU pipeline. It holds the processor privilege state, which is either kernel or user, in one bit. Each cycle it inspects the instruction presented by the decoder and any store that instruction makes. Any of the following makes the block take a trap:

- a store into the guarded low memory region while in user mode,
- a privileged instruction issued from user mode,
- an illegal instruction or a system call,
- a timer expiry or an external interrupt request.

In the same cycle the block blocks the instruction's side effects and redirects fetch to one fixed handler address. At the next clock edge it saves the instruction's PC and the previous mode, enters kernel mode and latches a cause code for the handler.

The guarded region is set by a fence register. In user mode, stores below the fence value are refused. Only kernel code can load the fence, the timer or the address-mapping tables, or perform IO. A return-from-trap instruction, usable only in kernel mode, puts back the saved mode and fetch PC. It then marks the saved mode as user. This gives kernel code its only way to hand control to user code. No instruction raises user code to kernel mode.

Top module: `priv_trap_top`

## Requirements
- R1: While reset is low and in the first cycle after it is released, `kernelMode` is 1, `fenceValue` is 0, `redirect` is 1 and `redirectPc` equals the reset vector parameter; `savedKernel` resets to 0.
- R2: In user mode, a store (`instValid` and `storeValid`) whose address is below `fenceValue` gets `storeAllow` 0 and raises a trap with cause 4; a store at or above the fence gets `storeAllow` 1 and no trap.
- R3: In kernel mode the fence has no effect: any store of a non-trapping instruction gets `storeAllow` 1.
- R4: An IO instruction (`instClass` 1) gets `ioAllow` 1 in kernel mode; in user mode `ioAllow` stays 0 and a trap with cause 3 is raised.
- R5: Timer load (class 2), fence write (class 3) and mapping-table write (class 4) are refused in user mode with a cause-3 trap, leaving `fenceValue` unchanged; in kernel mode a fence write loads `fenceData` into `fenceValue` at the clock edge.
- R6: An illegal instruction (class 7) traps with cause 2 and a system call (class 6) traps with cause 5, in either mode, through the same entry sequence.
- R7: When a trap is taken, `redirect` is 1 and `redirectPc` is the handler address in that cycle; after the clock edge `kernelMode` is 1, `savedPc` holds that cycle's `pc`, and `savedKernel` holds the mode before the trap.
- R8: The priority among events in one cycle is: illegal instruction (2), privileged violation (3), fence violation (4), system call (5), timer expiry (1), external interrupt (0). The cause codes are shown in brackets. `trapCause` shows the code of the trap taken.
- R9: A return-from-trap (class 5) in kernel mode gives `redirect` 1 with `redirectPc` equal to `savedPc` in that cycle; after the edge `kernelMode` equals the former `savedKernel` and `savedKernel` becomes 0. In user mode the instruction traps with cause 3.
- R10: A timer expiry raises a trap with cause 1 and an external request raises a trap with cause 0, whether or not an instruction is valid.
- R11: User mode only changes to kernel mode through a trap; instructions that do not trap leave the mode at user.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instValid | input | 1 | Decoded instruction present this cycle |
| instClass | input | 3 | Instruction class: 0 plain, 1 IO, 2 timer load, 3 fence write, 4 map write, 5 trap return, 6 system call, 7 illegal |
| storeValid | input | 1 | The instruction writes memory |
| storeAddr | input | ADDR_W | Store address |
| pc | input | ADDR_W | PC of the presented instruction |
| fenceData | input | ADDR_W | New fence value for a fence write |
| timerExpire | input | 1 | Timer expiry request |
| extIrq | input | 1 | External interrupt request |
| kernelMode | output | 1 | 1 = kernel, 0 = user |
| redirect | output | 1 | Fetch must restart at redirectPc |
| redirectPc | output | ADDR_W | Fetch restart address |
| trapCause | output | 3 | Cause of the most recent trap |
| savedPc | output | ADDR_W | PC saved at the most recent trap |
| savedKernel | output | 1 | Mode saved at the most recent trap |
| fenceValue | output | ADDR_W | Current fence |
| storeAllow | output | 1 | Store may commit |
| ioAllow | output | 1 | IO instruction may execute |
| timerLoadAllow | output | 1 | Timer load may execute |
| mapWriteAllow | output | 1 | Mapping-table write may execute |

## Verification
The assertions assume that the decoder never presents a store or instruction class without `instValid`. They also assume that during the reset-vector cycle the pipeline presents no instruction and no request, because the redirect for the boot vector overrides any other redirect. The bench drives every stimulus only on falling edges and clears all inputs in the cycle after each event. In the first cycle after reset it drives nothing. Each trap is followed by a return, so that the mode and the saved state start from a known value for the next scenario.

// File: rtl/priv_pkg.sv
package priv_pkg;

  typedef enum logic [2:0] {
    CLS_PLAIN   = 3'd0,
    CLS_IO      = 3'd1,
    CLS_TIMER   = 3'd2,
    CLS_FENCE   = 3'd3,
    CLS_MAP     = 3'd4,
    CLS_RETURN  = 3'd5,
    CLS_SYSCALL = 3'd6,
    CLS_ILLEGAL = 3'd7
  } instClassT;

  typedef enum logic [2:0] {
    CAUSE_EXT     = 3'd0,
    CAUSE_TIMER   = 3'd1,
    CAUSE_ILLEGAL = 3'd2,
    CAUSE_PRIV    = 3'd3,
    CAUSE_FENCE   = 3'd4,
    CAUSE_SYSCALL = 3'd5
  } causeT;

  // Strobes from the control decision to the state datapath
  typedef struct packed {
    logic  takeTrap;
    logic  doReturn;
    logic  fenceWe;
    causeT cause;
  } ctrlStrobeT;

endpackage

// File: rtl/priv_ctrl.sv
module priv_ctrl
  import priv_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  input  logic [2:0]        instClass,
  input  logic              storeValid,
  input  logic [ADDR_W-1:0] storeAddr,
  input  logic [ADDR_W-1:0] fence,
  input  logic              modeK,
  input  logic              timerExpire,
  input  logic              extIrq,
  output ctrlStrobeT        strobe,
  output logic              storeAllow,
  output logic              ioAllow,
  output logic              timerLoadAllow,
  output logic              mapWriteAllow
);

  instClassT cls;
  logic      privClass;
  logic      illegalHit;
  logic      privHit;
  logic      fenceHit;
  logic      syscallHit;
  logic      anyTrap;
  causeT     causeSel;

  assign cls = instClassT'(instClass);

  always_comb begin
    unique case (cls)
      CLS_IO, CLS_TIMER, CLS_FENCE, CLS_MAP, CLS_RETURN: privClass = 1'b1;
      default:                                           privClass = 1'b0;
    endcase
  end

  assign illegalHit = instValid && (cls == CLS_ILLEGAL);
  assign privHit    = instValid && privClass && !modeK;
  assign fenceHit   = instValid && storeValid && !modeK && (storeAddr < fence);
  assign syscallHit = instValid && (cls == CLS_SYSCALL);

  // Fixed priority: synchronous faults, system call, timer, external
  always_comb begin
    anyTrap  = 1'b1;
    causeSel = CAUSE_EXT;
    if (illegalHit)       causeSel = CAUSE_ILLEGAL;
    else if (privHit)     causeSel = CAUSE_PRIV;
    else if (fenceHit)    causeSel = CAUSE_FENCE;
    else if (syscallHit)  causeSel = CAUSE_SYSCALL;
    else if (timerExpire) causeSel = CAUSE_TIMER;
    else if (extIrq)      causeSel = CAUSE_EXT;
    else                  anyTrap  = 1'b0;
  end

  logic execOk;
  assign execOk = instValid && !anyTrap;

  assign strobe.takeTrap = anyTrap;
  assign strobe.cause    = causeSel;
  assign strobe.doReturn = execOk && (cls == CLS_RETURN);
  assign strobe.fenceWe  = execOk && (cls == CLS_FENCE);

  assign storeAllow     = execOk && storeValid;
  assign ioAllow        = execOk && (cls == CLS_IO);
  assign timerLoadAllow = execOk && (cls == CLS_TIMER);
  assign mapWriteAllow  = execOk && (cls == CLS_MAP);

  AST_ONE_EFFECT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ioAllow, timerLoadAllow, mapWriteAllow, strobe.fenceWe, strobe.doReturn})) // R4
    else $error("AST_ONE_EFFECT");

  AST_TRAP_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.takeTrap |-> !(storeAllow || ioAllow || timerLoadAllow || mapWriteAllow)) // R5
    else $error("AST_TRAP_BLOCKS");

  AST_USER_PRIV_NONE: assert property (@(posedge clk) disable iff (!rstN)
    !modeK |-> !(ioAllow || timerLoadAllow || mapWriteAllow || strobe.fenceWe || strobe.doReturn)) // R4
    else $error("AST_USER_PRIV_NONE");

endmodule

// File: rtl/priv_state.sv
module priv_state
  import priv_pkg::*;
#(
  parameter int              ADDR_W     = 32,
  parameter logic [ADDR_W-1:0] RESET_PC   = '0,
  parameter logic [ADDR_W-1:0] HANDLER_PC = 'h100
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobeT        strobe,
  input  logic [ADDR_W-1:0] pc,
  input  logic [ADDR_W-1:0] fenceData,
  output logic              modeK,
  output logic [ADDR_W-1:0] fence,
  output logic [ADDR_W-1:0] epc,
  output logic              savedK,
  output causeT             causeReg,
  output logic              redirect,
  output logic [ADDR_W-1:0] redirectPc
);

  logic bootPend;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeK    <= 1'b1;
      fence    <= '0;
      epc      <= '0;
      savedK   <= 1'b0;
      causeReg <= CAUSE_EXT;
      bootPend <= 1'b1;
    end else begin
      bootPend <= 1'b0;
      if (strobe.takeTrap) begin
        epc      <= pc;
        savedK   <= modeK;
        causeReg <= strobe.cause;
        modeK    <= 1'b1;
      end else if (strobe.doReturn) begin
        modeK  <= savedK;
        savedK <= 1'b0;
      end
      if (strobe.fenceWe) fence <= fenceData;
    end
  end

  always_comb begin
    redirect   = 1'b1;
    redirectPc = epc;
    if (!rstN || bootPend)    redirectPc = RESET_PC;
    else if (strobe.takeTrap) redirectPc = HANDLER_PC;
    else if (!strobe.doReturn) redirect  = 1'b0;
  end

  AST_TRAP_TO_KERNEL: assert property (@(posedge clk) disable iff (!rstN)
    strobe.takeTrap |=> modeK) // R7
    else $error("AST_TRAP_TO_KERNEL");

  AST_TRAP_SAVES_PC: assert property (@(posedge clk) disable iff (!rstN)
    strobe.takeTrap |=> (epc == $past(pc)) && (savedK == $past(modeK))) // R7
    else $error("AST_TRAP_SAVES_PC");

  AST_USER_STAYS_USER: assert property (@(posedge clk) disable iff (!rstN)
    (!modeK && !strobe.takeTrap) |=> !modeK) // R11
    else $error("AST_USER_STAYS_USER");

  AST_FENCE_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    !modeK |=> $stable(fence)) // R5
    else $error("AST_FENCE_LOCKED");

  AST_RETURN_MODE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doReturn |=> (modeK == $past(savedK)) && !savedK) // R9
    else $error("AST_RETURN_MODE");

  AST_CAUSE_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    causeReg <= CAUSE_SYSCALL) // R8
    else $error("AST_CAUSE_RANGE");

endmodule

// File: rtl/priv_trap_top.sv
module priv_trap_top
  import priv_pkg::*;
#(
  parameter int                ADDR_W     = 32,
  parameter logic [ADDR_W-1:0] RESET_PC   = '0,
  parameter logic [ADDR_W-1:0] HANDLER_PC = 'h100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  input  logic [2:0]        instClass,
  input  logic              storeValid,
  input  logic [ADDR_W-1:0] storeAddr,
  input  logic [ADDR_W-1:0] pc,
  input  logic [ADDR_W-1:0] fenceData,
  input  logic              timerExpire,
  input  logic              extIrq,
  output logic              kernelMode,
  output logic              redirect,
  output logic [ADDR_W-1:0] redirectPc,
  output logic [2:0]        trapCause,
  output logic [ADDR_W-1:0] savedPc,
  output logic              savedKernel,
  output logic [ADDR_W-1:0] fenceValue,
  output logic              storeAllow,
  output logic              ioAllow,
  output logic              timerLoadAllow,
  output logic              mapWriteAllow
);

  ctrlStrobeT strobe;
  causeT      causeReg;

  priv_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk            (clk),
    .rstN           (rstN),
    .instValid      (instValid),
    .instClass      (instClass),
    .storeValid     (storeValid),
    .storeAddr      (storeAddr),
    .fence          (fenceValue),
    .modeK          (kernelMode),
    .timerExpire    (timerExpire),
    .extIrq         (extIrq),
    .strobe         (strobe),
    .storeAllow     (storeAllow),
    .ioAllow        (ioAllow),
    .timerLoadAllow (timerLoadAllow),
    .mapWriteAllow  (mapWriteAllow)
  );

  priv_state #(
    .ADDR_W     (ADDR_W),
    .RESET_PC   (RESET_PC),
    .HANDLER_PC (HANDLER_PC)
  ) state_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .pc         (pc),
    .fenceData  (fenceData),
    .modeK      (kernelMode),
    .fence      (fenceValue),
    .epc        (savedPc),
    .savedK     (savedKernel),
    .causeReg   (causeReg),
    .redirect   (redirect),
    .redirectPc (redirectPc)
  );

  assign trapCause = causeReg;

endmodule

// File: tb/priv_trap_top_tb.sv
module priv_trap_top_tb_top;

  localparam int          AW      = 32;
  localparam logic [31:0] RST_V   = 32'h0000_0040;
  localparam logic [31:0] HND_V   = 32'h0000_0200;

  logic          clk = 1'b0;
  logic          rstN;
  logic          instValid, storeValid, timerExpire, extIrq;
  logic [2:0]    instClass;
  logic [AW-1:0] storeAddr, pc, fenceData;
  logic          kernelMode, redirect, savedKernel;
  logic [AW-1:0] redirectPc, savedPc, fenceValue;
  logic [2:0]    trapCause;
  logic          storeAllow, ioAllow, timerLoadAllow, mapWriteAllow;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  priv_trap_top #(.ADDR_W(AW), .RESET_PC(RST_V), .HANDLER_PC(HND_V)) dut_i (
    .clk, .rstN, .instValid, .instClass, .storeValid, .storeAddr, .pc, .fenceData,
    .timerExpire, .extIrq, .kernelMode, .redirect, .redirectPc, .trapCause,
    .savedPc, .savedKernel, .fenceValue, .storeAllow, .ioAllow,
    .timerLoadAllow, .mapWriteAllow
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    instValid = 0; instClass = 0; storeValid = 0; storeAddr = 0;
    pc = 0; fenceData = 0; timerExpire = 0; extIrq = 0;
  endtask

  // Drive at falling edge; combinational outputs are sampled 1 ns later
  task automatic drive(input logic v, input logic [2:0] c, input logic st,
                       input logic [31:0] a, input logic [31:0] p,
                       input logic [31:0] fd, input logic t, input logic x);
    @(negedge clk);
    instValid = v; instClass = c; storeValid = st; storeAddr = a;
    pc = p; fenceData = fd; timerExpire = t; extIrq = x;
    #1;
  endtask

  task automatic afterEdge();
    @(posedge clk); #1;
    idle();
  endtask

  // Trap expected in the driven cycle
  task automatic expectTrap(input string req, input logic [2:0] cause,
                            input logic [31:0] p, input logic prevK);
    check(req, "redirect", redirect, 1);
    check(req, "redirectPc", redirectPc, HND_V);
    check(req, "storeAllow", storeAllow, 0);
    check(req, "ioAllow", ioAllow, 0);
    afterEdge();
    check(req, "trapCause", trapCause, cause);
    check(req, "kernelMode", kernelMode, 1);
    check(req, "savedPc", savedPc, p);
    check(req, "savedKernel", savedKernel, prevK);
  endtask

  task automatic doReturn(input string req, input logic [31:0] expPc, input logic expK);
    drive(1, 3'd5, 0, 0, 32'h700, 0, 0, 0);
    check(req, "return redirect", redirect, 1);
    check(req, "return redirectPc", redirectPc, expPc);
    afterEdge();
    check(req, "return kernelMode", kernelMode, expK);
    check(req, "return savedKernel", savedKernel, 0);
  endtask

  task automatic testReset();
    idle();
    rstN = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1; #1;
    check("R1", "kernelMode", kernelMode, 1);
    check("R1", "fenceValue", fenceValue, 0);
    check("R1", "redirect", redirect, 1);
    check("R1", "redirectPc", redirectPc, RST_V);
    check("R1", "savedKernel", savedKernel, 0);
    afterEdge();
    check("R1", "redirect drops", redirect, 0);
  endtask

  task automatic testKernel();
    drive(1, 3'd3, 0, 0, 32'h44, 32'h1000, 0, 0);
    afterEdge();
    check("R5", "kernel fence write", fenceValue, 32'h1000);
    drive(1, 3'd0, 1, 32'h10, 32'h48, 0, 0, 0);
    check("R3", "kernel low store", storeAllow, 1);
    check("R3", "no redirect", redirect, 0);
    afterEdge();
    drive(1, 3'd1, 0, 0, 32'h4C, 0, 0, 0);
    check("R4", "kernel io", ioAllow, 1);
    afterEdge();
    drive(1, 3'd7, 0, 0, 32'h50, 0, 0, 0);
    expectTrap("R6", 3'd2, 32'h50, 1);
    doReturn("R9", 32'h50, 1);
    doReturn("R9", 32'h50, 0);
  endtask

  task automatic testUserStores();
    drive(1, 3'd0, 1, 32'h0FFF, 32'h2000, 0, 0, 0);
    expectTrap("R2", 3'd4, 32'h2000, 0);
    doReturn("R9", 32'h2000, 0);
    drive(1, 3'd0, 1, 32'h1000, 32'h2004, 0, 0, 0);
    check("R2", "store at fence", storeAllow, 1);
    check("R2", "no redirect at fence", redirect, 0);
    afterEdge();
    for (int i = 0; i < 4; i++) begin
      drive(1, 3'd0, 1, 32'h3000 + i, 32'h2008 + i, 0, 0, 0);
      afterEdge();
      check("R11", "user stays user", kernelMode, 0);
    end
  endtask

  task automatic testUserPriv();
    drive(1, 3'd1, 0, 0, 32'h2100, 0, 0, 0);
    check("R4", "user io blocked", ioAllow, 0);
    expectTrap("R4", 3'd3, 32'h2100, 0);
    doReturn("R9", 32'h2100, 0);
    drive(1, 3'd3, 0, 0, 32'h2104, 32'h0, 0, 0);
    expectTrap("R5", 3'd3, 32'h2104, 0);
    check("R5", "fence unchanged", fenceValue, 32'h1000);
    doReturn("R9", 32'h2104, 0);
    drive(1, 3'd2, 0, 0, 32'h2108, 0, 0, 0);
    check("R5", "timer load blocked", timerLoadAllow, 0);
    expectTrap("R5", 3'd3, 32'h2108, 0);
    doReturn("R9", 32'h2108, 0);
    drive(1, 3'd4, 0, 0, 32'h210C, 0, 0, 0);
    check("R5", "map write blocked", mapWriteAllow, 0);
    expectTrap("R5", 3'd3, 32'h210C, 0);
    doReturn("R9", 32'h210C, 0);
    drive(1, 3'd5, 0, 0, 32'h2110, 0, 0, 0);
    expectTrap("R9", 3'd3, 32'h2110, 0);
    doReturn("R9", 32'h2110, 0);
    drive(1, 3'd6, 0, 0, 32'h2114, 0, 0, 0);
    expectTrap("R6", 3'd5, 32'h2114, 0);
    doReturn("R6", 32'h2114, 0);
  endtask

  task automatic testEvents();
    drive(0, 3'd0, 0, 0, 32'h2200, 0, 1, 0);
    expectTrap("R10", 3'd1, 32'h2200, 0);
    doReturn("R10", 32'h2200, 0);
    drive(0, 3'd0, 0, 0, 32'h2204, 0, 0, 1);
    expectTrap("R10", 3'd0, 32'h2204, 0);
    doReturn("R10", 32'h2204, 0);
    drive(1, 3'd7, 1, 32'h10, 32'h2208, 0, 1, 1);
    expectTrap("R8", 3'd2, 32'h2208, 0);
    doReturn("R8", 32'h2208, 0);
    drive(1, 3'd1, 1, 32'h10, 32'h220C, 0, 1, 1);
    expectTrap("R8", 3'd3, 32'h220C, 0);
    doReturn("R8", 32'h220C, 0);
    drive(1, 3'd6, 1, 32'h10, 32'h2210, 0, 1, 1);
    expectTrap("R8", 3'd4, 32'h2210, 0);
    doReturn("R8", 32'h2210, 0);
    drive(1, 3'd6, 0, 0, 32'h2214, 0, 1, 1);
    expectTrap("R8", 3'd5, 32'h2214, 0);
    doReturn("R8", 32'h2214, 0);
    drive(1, 3'd0, 1, 32'h4000, 32'h2218, 0, 1, 1);
    check("R8", "store blocked by timer", storeAllow, 0);
    expectTrap("R8", 3'd1, 32'h2218, 0);
    doReturn("R8", 32'h2218, 0);
    drive(1, 3'd0, 0, 0, 32'h221C, 0, 0, 0);
    afterEdge();
    check("R7", "mode after return", kernelMode, 0);
  endtask

  initial begin
    fork
      begin
        testReset();
        testKernel();
        testUserStores();
        testUserPriv();
        testEvents();
      end
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule